// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Controller

This block sits on an 8-bit console cartridge between the CPU, the video chip and the ROM arrays. CPU writes anywhere in the upper 32 KB address window land in a small set of control registers. From those registers the block turns each CPU program address into an address inside an 8 KB-banked program ROM. It also turns each video pattern-table address into an address inside a 1 KB-banked character ROM.

The same register set selects the nametable mirroring mode and the enable and write-protect flags of the work RAM at $6000-$7FFF. A scanline interrupt unit counts video lines. It is reloaded from a latch, and it raises an interrupt line when its count reaches zero while enabled. Eight bank registers are loaded indirectly: a command write picks one of them and the following data write fills it. Two command bits set the layout. One swaps the switchable and fixed program windows. The other swaps the two halves of the pattern space between the 2 KB and 1 KB character banks.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A register write happens only when `cpu_wr` is high and `cpu_addr[15]` is 1. The target is chosen by `{cpu_addr[14:13], cpu_addr[0]}` alone: 0 command, 1 bank data, 2 mirroring, 3 work RAM, 4 counter, 5 latch, 6 interrupt off, 7 interrupt on. Writes with `cpu_addr[15]`=0 change nothing.
- R2: Bits 2:0 of the command pick the bank register that the next bank-data write loads. Bit 6 is the program layout bit and bit 7 is the character swap bit.
- R3: Program bank numbers from registers 6 and 7 are ANDed with 0x1F when `PRG_KB` is 256, and with 0x0F otherwise.
- R4: `prg_addr_o` is the bank number followed by `cpu_addr[12:0]`. The bank is chosen by `cpu_addr[14:13]`, as follows. With layout bit 0: window 0 uses register 6 and window 2 uses the second-to-last bank. With layout bit 1: window 0 uses the second-to-last bank and window 2 uses register 6. Window 1 always uses register 7. Window 3 always uses the last bank.
- R5: `chr_addr_o` is an 8-bit 1 KB bank number followed by `ppu_addr[9:0]`. The 1 KB slot is `ppu_addr[12:10]`. Let B = 4 when the swap bit is set, else 0. Register r in 0..1 covers slots B^(2r) and B^(2r)+1, with bank values (reg & 0xFE) and (reg & 0xFE)+1. Register r in 2..5 covers slot B^(r+2).
- R6: A mirroring write sets `mirror_o` to 2 (single screen, upper) when data bit 6 is 1. Otherwise it sets 1 (horizontal) when bit 0 is 1 and 0 (vertical) when bit 0 is 0. The write has no effect while `four_screen` is 1.
- R7: A work RAM write loads `wram_en_o` from data bit 7 and `wram_wp_o` from data bit 6.
- R8: A counter write loads the scanline counter and a latch write loads the reload latch. On each `scanline` pulse the counter reloads from the latch if it is zero, otherwise it decrements by one. A counter write in the same cycle takes precedence.
- R9: An interrupt-on write enables the interrupt. An interrupt-off write disables it and clears a pending interrupt. `irq_o` goes high the cycle after a scanline pulse leaves the counter at zero while enabled, and it stays high until the next interrupt-off write.
- R10: After reset, all bank registers and the command are zero, `mirror_o` is 0, work RAM is disabled and unprotected, the counter and latch are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for decoding and translation |
| cpu_wdata | input | 8 | CPU write data |
| four_screen | input | 1 | Cartridge wired for four-screen layout |
| scanline | input | 1 | One-cycle pulse per video line |
| ppu_addr | input | 13 | Video pattern-table address |
| prg_addr_o | output | PRG_BW+13 | Program ROM address |
| chr_addr_o | output | 18 | Character ROM address |
| mirror_o | output | 2 | Mirroring mode: 0 vertical, 1 horizontal, 2 single upper |
| wram_en_o | output | 1 | Work RAM enable |
| wram_wp_o | output | 1 | Work RAM write protect |
| irq_o | output | 1 | Scanline interrupt, active high |

## Verification
The assertions take for granted that `scanline` is a one-cycle pulse. They also assume a counter write and a scanline pulse never meet in the same cycle, except where the reload and decrement properties exclude that case explicitly. The stimulus keeps every write and every line pulse apart by at least one idle cycle. It changes `cpu_addr` with the strobe low when it probes translation, so probing never disturbs the registers. The program-size variants are covered by a second instance with a 256 KB program ROM driven by the same stimulus.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_HI = 2'd2
    } mirror_e;

    typedef enum logic [2:0] {
        SEL_CMD     = 3'd0,
        SEL_DATA    = 3'd1,
        SEL_MIRROR  = 3'd2,
        SEL_WRAM    = 3'd3,
        SEL_CNT     = 3'd4,
        SEL_LATCH   = 3'd5,
        SEL_IRQ_OFF = 3'd6,
        SEL_IRQ_ON  = 3'd7
    } sel_e;

    localparam int NUM_BANK_REGS = 8;

    typedef logic [NUM_BANK_REGS-1:0][7:0] bank_arr_t;

endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  sel_e      sel,
    input  logic [7:0] wdata,
    input  logic      four_screen,
    output bank_arr_t banks,
    output logic      prg_mode,
    output logic      chr_swap,
    output mirror_e   mirror,
    output logic      wram_en,
    output logic      wram_wp
);

    typedef struct packed {
        bank_arr_t  bank;
        logic [7:0] cmd;
        mirror_e    mir;
        logic       wen;
        logic       wp;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (sel)
                SEL_CMD:    regs_d.cmd = wdata;
                SEL_DATA:   regs_d.bank[regs_q.cmd[2:0]] = wdata;
                SEL_MIRROR: if (!four_screen) begin
                    if (wdata[6])      regs_d.mir = MIR_ONE_HI;
                    else if (wdata[0]) regs_d.mir = MIR_HORZ;
                    else               regs_d.mir = MIR_VERT;
                end
                SEL_WRAM: begin
                    regs_d.wen = wdata[7];
                    regs_d.wp  = wdata[6];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign banks    = regs_q.bank;
    assign prg_mode = regs_q.cmd[6];
    assign chr_swap = regs_q.cmd[7];
    assign mirror   = regs_q.mir;
    assign wram_en  = regs_q.wen;
    assign wram_wp  = regs_q.wp;

    // R1: nothing moves without a qualified write
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R2: data write lands in the register named by the previous command
    a_r2_data_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=> regs_q.bank[$past(regs_q.cmd[2:0])] == $past(wdata));

    // R6: four-screen wiring freezes mirroring
    a_r6_four_screen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        four_screen |=> $stable(regs_q.mir));

    // R7: work RAM flags follow the data bits
    a_r7_wram_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_WRAM) |=> (wram_en == $past(wdata[7])) && (wram_wp == $past(wdata[6])));

endmodule

// File: rtl/cbc_prg_map.sv
module cbc_prg_map
    import cbc_pkg::*;
#(
    parameter int PRG_KB = 128,
    localparam int PRG_BANKS = PRG_KB / 8,
    localparam int PRG_BW = $clog2(PRG_BANKS)
) (
    input  logic [1:0]        window,
    input  logic              prg_mode,
    input  logic [7:0]        bank6,
    input  logic [7:0]        bank7,
    output logic [PRG_BW-1:0] bank_o
);

    localparam logic [7:0] SECOND_LAST = 8'(PRG_BANKS - 2);
    localparam logic [7:0] LAST_BANK   = 8'(PRG_BANKS - 1);

    logic [7:0] mask;
    logic [7:0] pick;

    generate
        if (PRG_KB == 256) begin : g_wide
            assign mask = 8'h1F;
        end else begin : g_narrow
            assign mask = 8'h0F;
        end
    endgenerate

    always_comb begin
        unique case (window)
            2'd0:    pick = prg_mode ? SECOND_LAST : (bank6 & mask);
            2'd1:    pick = bank7 & mask;
            2'd2:    pick = prg_mode ? (bank6 & mask) : SECOND_LAST;
            default: pick = LAST_BANK;
        endcase
        bank_o = pick[PRG_BW-1:0];
    end

endmodule

// File: rtl/cbc_chr_map.sv
module cbc_chr_map
    import cbc_pkg::*;
(
    input  logic [2:0] slot,
    input  logic       chr_swap,
    input  bank_arr_t  banks,
    output logic [7:0] bank_o
);

    logic [2:0] eff;

    always_comb begin
        eff = slot ^ {chr_swap, 2'b00};
        if (!eff[2]) bank_o = {banks[{2'b00, eff[1]}][7:1], eff[0]};
        else         bank_o = banks[3'({1'b0, eff[1:0]}) + 3'd2];
    end

endmodule

// File: rtl/cbc_irq.sv
module cbc_irq
    import cbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  sel_e       sel,
    input  logic [7:0] wdata,
    input  logic       scanline,
    output logic       irq
);

    typedef struct packed {
        logic [7:0] cnt;
        logic [7:0] latch;
        logic       en;
        logic       pend;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [7:0] line_next;
    logic       cnt_wr;

    assign cnt_wr = wr_en && (sel == SEL_CNT);

    always_comb begin
        irq_d     = irq_q;
        line_next = (irq_q.cnt == 8'd0) ? irq_q.latch : irq_q.cnt - 8'd1;
        if (scanline) begin
            irq_d.cnt = line_next;
            if (line_next == 8'd0 && irq_q.en) irq_d.pend = 1'b1;
        end
        if (wr_en) begin
            unique case (sel)
                SEL_CNT:     irq_d.cnt   = wdata;
                SEL_LATCH:   irq_d.latch = wdata;
                SEL_IRQ_OFF: begin
                    irq_d.en   = 1'b0;
                    irq_d.pend = 1'b0;
                end
                SEL_IRQ_ON:  irq_d.en = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q.pend;

    // R8: reload from latch at zero
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (scanline && !cnt_wr && irq_q.cnt == 8'd0) |=> irq_q.cnt == $past(irq_q.latch));

    // R8: decrement otherwise
    a_r8_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (scanline && !cnt_wr && irq_q.cnt != 8'd0) |=> irq_q.cnt == $past(irq_q.cnt) - 8'd1);

    // R9: disable write clears pending and enable
    a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_IRQ_OFF) |=> (!irq && !irq_q.en));

    // R9: a new interrupt only appears with the counter at zero
    a_r9_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q.pend) |-> (irq_q.cnt == 8'd0 || $past(cnt_wr)));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int PRG_KB = 128,
    localparam int PRG_BANKS = PRG_KB / 8,
    localparam int PRG_BW = $clog2(PRG_BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               four_screen,
    input  logic               scanline,
    input  logic [12:0]        ppu_addr,
    output logic [PRG_BW+12:0] prg_addr_o,
    output logic [17:0]        chr_addr_o,
    output logic [1:0]         mirror_o,
    output logic               wram_en_o,
    output logic               wram_wp_o,
    output logic               irq_o
);

    logic              wr_hit;
    sel_e              sel;
    bank_arr_t         banks;
    logic              prg_mode;
    logic              chr_swap;
    mirror_e           mirror;
    logic [PRG_BW-1:0] prg_bank;
    logic [7:0]        chr_bank;

    assign wr_hit = cpu_wr && cpu_addr[15];
    assign sel    = sel_e'({cpu_addr[14:13], cpu_addr[0]});

    cbc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_hit),
        .sel         (sel),
        .wdata       (cpu_wdata),
        .four_screen (four_screen),
        .banks       (banks),
        .prg_mode    (prg_mode),
        .chr_swap    (chr_swap),
        .mirror      (mirror),
        .wram_en     (wram_en_o),
        .wram_wp     (wram_wp_o)
    );

    cbc_prg_map #(.PRG_KB(PRG_KB)) u_prg (
        .window   (cpu_addr[14:13]),
        .prg_mode (prg_mode),
        .bank6    (banks[6]),
        .bank7    (banks[7]),
        .bank_o   (prg_bank)
    );

    cbc_chr_map u_chr (
        .slot     (ppu_addr[12:10]),
        .chr_swap (chr_swap),
        .banks    (banks),
        .bank_o   (chr_bank)
    );

    cbc_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_hit),
        .sel      (sel),
        .wdata    (cpu_wdata),
        .scanline (scanline),
        .irq      (irq_o)
    );

    assign prg_addr_o = {prg_bank, cpu_addr[12:0]};
    assign chr_addr_o = {chr_bank, ppu_addr[9:0]};
    assign mirror_o   = mirror;

    // R4: top window is pinned to the last bank
    a_r4_top_window_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> prg_addr_o[PRG_BW+12:13] == PRG_BW'(PRG_BANKS - 1));

    // R6: mirroring never takes the unused code
    a_r6_mirror_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_o != 2'd3);

endmodule

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/100ps
module cart_bank_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        four_screen = 1'b0;
    logic        scanline = 1'b0;
    logic [12:0] ppu_addr = 13'h0000;

    logic [16:0] prg_a;
    logic [17:0] chr_a;
    logic [1:0]  mir_a;
    logic        wen_a, wp_a, irq_a;

    logic [17:0] prg_b;
    logic [17:0] chr_b;
    logic [1:0]  mir_b;
    logic        wen_b, wp_b, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int mbank[8];
    int mcmd, mmir, mwen, mwp, mcnt, mlatch, men, mpend;

    always #4 clk = ~clk;

    cart_bank_ctrl #(.PRG_KB(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .four_screen(four_screen), .scanline(scanline),
        .ppu_addr(ppu_addr), .prg_addr_o(prg_a), .chr_addr_o(chr_a),
        .mirror_o(mir_a), .wram_en_o(wen_a), .wram_wp_o(wp_a), .irq_o(irq_a)
    );

    cart_bank_ctrl #(.PRG_KB(256)) u_dut_big (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .four_screen(four_screen), .scanline(scanline),
        .ppu_addr(ppu_addr), .prg_addr_o(prg_b), .chr_addr_o(chr_b),
        .mirror_o(mir_b), .wram_en_o(wen_b), .wram_wp_o(wp_b), .irq_o(irq_b)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference, stepped on every rising edge
    always @(posedge clk) begin
        int nxt;
        if (!rst_n) begin
            foreach (mbank[i]) mbank[i] = 0;
            mcmd = 0; mmir = 0; mwen = 0; mwp = 0;
            mcnt = 0; mlatch = 0; men = 0; mpend = 0;
        end else begin
            if (scanline) begin
                nxt = (mcnt == 0) ? mlatch : mcnt - 1;
                mcnt = nxt;
                if (nxt == 0 && men == 1) mpend = 1;
            end
            if (cpu_wr && cpu_addr[15]) begin
                case ({cpu_addr[14:13], cpu_addr[0]})
                    3'd0: mcmd = cpu_wdata;
                    3'd1: mbank[mcmd & 7] = cpu_wdata;
                    3'd2: if (!four_screen) mmir = cpu_wdata[6] ? 2 : (cpu_wdata[0] ? 1 : 0);
                    3'd3: begin mwen = cpu_wdata[7]; mwp = cpu_wdata[6]; end
                    3'd4: mcnt = cpu_wdata;
                    3'd5: mlatch = cpu_wdata;
                    3'd6: begin men = 0; mpend = 0; end
                    default: men = 1;
                endcase
            end
        end
    end

    // per-clock comparison of the registered outputs
    always @(negedge clk) begin
        if (!done) begin
            chk(rst_n ? "R9" : "R10", "irq", irq_a, mpend);
            chk(rst_n ? "R6" : "R10", "mirror", mir_a, mmir);
            chk(rst_n ? "R7" : "R10", "wram_en", wen_a, mwen);
            chk(rst_n ? "R7" : "R10", "wram_wp", wp_a, mwp);
        end
    end

    function automatic int exp_prg(input int w, input int kb);
        int mask, nb, mode;
        mask = (kb == 256) ? 31 : 15;
        nb   = kb / 8;
        mode = (mcmd >> 6) & 1;
        case (w)
            0: return mode ? nb - 2 : (mbank[6] & mask);
            1: return mbank[7] & mask;
            2: return mode ? (mbank[6] & mask) : nb - 2;
            default: return nb - 1;
        endcase
    endfunction

    function automatic int exp_chr(input int slot);
        int base;
        base = (mcmd & 128) ? 4 : 0;
        for (int r = 0; r < 2; r++) begin
            if (slot == (base ^ (r * 2)))     return mbank[r] & 254;
            if (slot == (base ^ (r * 2)) + 1) return (mbank[r] & 254) + 1;
        end
        for (int r = 2; r < 6; r++)
            if (slot == (base ^ (r + 2))) return mbank[r];
        return -1;
    endfunction

    task automatic probe_maps(input string req);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            cpu_wr   = 1'b0;
            cpu_addr = 16'h8000 | 16'(w << 13) | 16'h0456;
            #1;
            chk(req, "prg bank", int'(prg_a[16:13]), exp_prg(w, 128));
            chk("R3", "prg bank 256KB", int'(prg_b[17:13]), exp_prg(w, 256));
            chk(req, "prg offset", int'(prg_a[12:0]), 'h0456);
        end
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            ppu_addr = 13'(s << 10) | 13'h0155;
            #1;
            chk("R5", "chr bank", int'(chr_a[17:10]), exp_chr(s));
            chk("R5", "chr offset", int'(chr_a[9:0]), 'h155);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic line_pulse();
        @(negedge clk);
        scanline = 1'b1;
        @(negedge clk);
        scanline = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state of translation
        probe_maps("R10");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: writes below $8000 are ignored
        wr(16'h6001 | 16'h2000, 8'hC0);
        wr(16'h2000, 8'h01);
        @(negedge clk);
        chk("R1", "wram_en after low write", wen_a, 0);
        chk("R1", "mirror after low write", mir_a, 0);

        // R2: load all bank registers, using aliased addresses for R1 decode
        begin
            logic [7:0] vals[8] = '{8'h35, 8'h0B, 8'h21, 8'h22, 8'h23, 8'h24, 8'h35, 8'h1A};
            for (int r = 0; r < 8; r++) begin
                wr((r % 2) ? 16'h9FFE : 16'h8000, 8'(r));
                wr((r % 2) ? 16'h8001 : 16'h9F03, vals[r]);
            end
        end
        probe_maps("R4");
        wr(16'h8000, 8'hC0);
        probe_maps("R4");
        wr(16'h8000, 8'h40);
        probe_maps("R2");
        wr(16'h8000, 8'h80);
        probe_maps("R5");

        // R6: mirroring
        wr(16'hA000, 8'h01);
        wr(16'hA000, 8'h41);
        wr(16'hBFFE, 8'h00);
        wr(16'hA000, 8'h01);
        four_screen = 1'b1;
        wr(16'hA000, 8'h40);
        @(negedge clk);
        chk("R6", "four-screen hold", mir_a, 1);
        four_screen = 1'b0;

        // R7: work RAM flags
        wr(16'hA001, 8'h80);
        wr(16'hA001, 8'hC0);
        @(negedge clk);
        chk("R7", "wram protect", wp_a, 1);
        wr(16'hA001, 8'h40);

        // R8 and R9: scanline interrupt
        wr(16'hC001, 8'd3);
        wr(16'hC000, 8'd0);
        wr(16'hE001, 8'h00);
        for (int i = 0; i < 3; i++) line_pulse();
        @(negedge clk);
        chk("R9", "no irq before zero", irq_a, 0);
        line_pulse();
        @(negedge clk);
        chk("R9", "irq at zero", irq_a, 1);
        line_pulse();
        chk("R9", "irq held", irq_a, 1);
        wr(16'hE000, 8'h00);
        chk("R9", "irq cleared", irq_a, 0);
        for (int i = 0; i < 6; i++) line_pulse();
        chk("R8", "disabled no irq", irq_a, 0);
        wr(16'hC001, 8'd0);
        wr(16'hC000, 8'd1);
        wr(16'hE001, 8'h00);
        line_pulse();
        chk("R8", "decrement to zero irq", irq_a, 1);
        wr(16'hE000, 8'h00);
        wr(16'hE001, 8'h00);
        line_pulse();
        chk("R8", "zero latch reload irq", irq_a, 1);
        repeat (4) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule